// File: doc/BRIEF.md
# Debug Word Read Access Checker

This block serves a privileged debug read of one word from a page of protected memory. A request carries a linear address, a mode bit that selects a 64-bit or a 32-bit read, and two facts already worked out upstream: whether the address falls inside the protected region, and whether a metadata-modifying operation is currently in progress. The block walks a fixed sequence of checks. It looks up the per-page metadata through a one-cycle lookup port, reads the backing 64-bit word through a one-cycle read port, and finishes with a single-cycle done pulse.

Each transaction ends in one of three ways. It may end in a fault, either a protection fault or a page fault. It may end in a soft "page not debuggable" return: no fault is raised, a status code is returned and the zero flag is set. Or it may end in success, with the data word. Regular and thread-control pages return the raw word at the width of the mode. Version-slot pages return a collapsed value instead of the raw word: all ones or all zeros.

Top module: `dbg_word_reader`

## Requirements
- R1: A request is taken only while the block is idle. `req_valid` asserted during a transaction is ignored. Every transaction ends with `done` high for exactly one cycle, and the results are valid in that cycle.
- R2: A misaligned address gives fault code 1 (protection) before any other check, and no metadata lookup or memory read is issued. In wide mode `req_wide`=1 and the address must have bits [2:0] at zero. In narrow mode the address must have bits [1:0] at zero.
- R3: After alignment the checks run in this order, and the first that fails decides the outcome. Address outside the region gives fault 2 (page). Metadata operation busy gives fault 1. Metadata valid bit 0 gives fault 2. A page type other than 1 (thread-control), 2 (regular) or 3 (version-slot) gives fault 2.
- R4: A page that passes the R3 checks and has its pending or modified bit set ends without a fault (fault 0). It returns status 19 with `zf`=1 and `rd_data`=0, and no memory read is issued. This test comes before the R5 and R6 checks.
- R5: For a thread-control page, an in-page offset (address bits [11:0]) at or above `TCS_LIMIT` gives fault 1.
- R6: For a regular or thread-control page whose owner debug bit is 0, the result is fault 1.
- R7: A successful wide read returns the 64-bit word at word address `addr[ADDR_W-1:3]`, with status 0 and `zf`=0.
- R8: A successful narrow read returns in bits [31:0] the half of that word chosen by address bit 2 (1 selects bits [63:32]). Bits [63:32] of `rd_data` are zero.
- R9: For a version-slot page the word is read with its low 3 bits cleared. A nonzero result returns all ones at the mode's width, and a zero result returns zero. The owner debug bit is not checked for these pages.
- R10: The page permission bits `meta_perm` have no effect on any outcome.
- R11: `oth_flags` (carry, parity, auxiliary, overflow, sign) is zero at every non-fault done.
- R12: `meta_rd_en` is high for one cycle with `meta_page` = `addr[ADDR_W-1:12]`, and the metadata inputs are sampled in the following cycle. `mem_rd_en` is high for one cycle with `mem_rd_addr` = `addr[ADDR_W-1:3]`, and `mem_rd_data` is sampled in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Linear address of the word |
| req_wide | input | 1 | 1: 64-bit read, 0: 32-bit read |
| req_in_region | input | 1 | Address lies inside the protected region |
| req_meta_busy | input | 1 | Metadata-modifying operation in progress |
| meta_rd_en | output | 1 | Metadata lookup strobe |
| meta_page | output | ADDR_W-12 | Page index looked up |
| meta_valid | input | 1 | Page entry valid |
| meta_type | input | 3 | Page type |
| meta_pending | input | 1 | Page pending bit |
| meta_modified | input | 1 | Page modified bit |
| meta_owner_dbg | input | 1 | Owner debug attribute |
| meta_perm | input | 3 | Page permission bits (ignored) |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W-3 | 64-bit word address |
| mem_rd_data | input | 64 | Word returned one cycle after the strobe |
| done | output | 1 | Single-cycle completion pulse |
| fault | output | 2 | 0 none, 1 protection, 2 page |
| rd_data | output | 64 | Read result |
| status | output | STATUS_W | Status code (0 or 19) |
| zf | output | 1 | Zero flag |
| oth_flags | output | 5 | Other arithmetic flags, always cleared |

## Verification
Some properties are checked by assertions on every cycle. These are the one-cycle width of `done` and of `meta_rd_en`, and the fact that a request arriving mid-transaction leaves the captured address unchanged. The assertions also check that a misaligned request ends in a protection fault two cycles after acceptance, that a not-debuggable return never follows a memory read, that `zf` agrees with the status code, and that the upper half of a narrow result is zero. Other behaviour shows only in the bench's scenarios: the full check priority order across stacked failing conditions, the thread-control offset limit, the collapse of version-slot values, and the indifference to the permission bits.

// File: rtl/dbgrd_pkg.sv
package dbgrd_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PROT = 2'd1,
    FLT_PAGE = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_META,
    ST_DATA
  } state_e;

  localparam logic [2:0] PG_THREAD = 3'd1;
  localparam logic [2:0] PG_REG    = 3'd2;
  localparam logic [2:0] PG_VSLOT  = 3'd3;

  typedef struct packed {
    logic       valid;
    logic [2:0] ptype;
    logic       pending;
    logic       modified;
    logic       owner_dbg;
  } page_meta_t;

endpackage

// File: rtl/dbgrd_rst_sync.sv
module dbgrd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/dbgrd_precheck.sv
module dbgrd_precheck
  import dbgrd_pkg::*;
#(
  parameter int unsigned WOFS_W = 3
) (
  input  logic [WOFS_W-1:0] addr_lo,
  input  logic              wide,
  input  logic              in_region,
  input  logic              meta_busy,
  output fault_e            fault
);

  logic mis_wide;
  logic mis_narrow;
  logic misaligned;

  assign mis_wide   = |addr_lo;
  assign mis_narrow = |addr_lo[WOFS_W-2:0];
  assign misaligned = wide ? mis_wide : mis_narrow;

  always_comb begin
    if (misaligned) begin
      fault = FLT_PROT;
    end else if (!in_region) begin
      fault = FLT_PAGE;
    end else if (meta_busy) begin
      fault = FLT_PROT;
    end else begin
      fault = FLT_NONE;
    end
  end

endmodule

// File: rtl/dbgrd_page_check.sv
module dbgrd_page_check
  import dbgrd_pkg::*;
#(
  parameter int unsigned OFS_W     = 12,
  parameter int unsigned TCS_LIMIT = 4096
) (
  input  page_meta_t       meta,
  input  logic [OFS_W-1:0] ofs,
  output fault_e           fault,
  output logic             nodbg,
  output logic             is_vslot
);

  localparam logic [OFS_W:0] LIM = (OFS_W+1)'(TCS_LIMIT);

  logic is_thread;
  logic is_reg;
  logic type_ok;
  logic ofs_over;

  assign is_thread = (meta.ptype == PG_THREAD);
  assign is_reg    = (meta.ptype == PG_REG);
  assign is_vslot  = (meta.ptype == PG_VSLOT);
  assign type_ok   = is_thread | is_reg | is_vslot;
  assign ofs_over  = ({1'b0, ofs} >= LIM);

  always_comb begin
    fault = FLT_NONE;
    nodbg = 1'b0;
    if (!meta.valid) begin
      fault = FLT_PAGE;
    end else if (!type_ok) begin
      fault = FLT_PAGE;
    end else if (meta.pending || meta.modified) begin
      nodbg = 1'b1;
    end else if (is_thread && ofs_over) begin
      fault = FLT_PROT;
    end else if ((is_reg || is_thread) && !meta.owner_dbg) begin
      fault = FLT_PROT;
    end
  end

endmodule

// File: rtl/dbgrd_word_format.sv
module dbgrd_word_format #(
  parameter int unsigned WORD_W = 64
) (
  input  logic              wide,
  input  logic              hi_sel,
  input  logic              vslot,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] data
);

  localparam int unsigned HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] masked;
  logic              nz;
  logic [HALF_W-1:0] half;

  assign masked = word & ~(WORD_W'(7));
  assign nz     = |masked;
  assign half   = hi_sel ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];

  always_comb begin
    if (vslot) begin
      data = wide ? {WORD_W{nz}} : {{HALF_W{1'b0}}, {HALF_W{nz}}};
    end else begin
      data = wide ? word : {{HALF_W{1'b0}}, half};
    end
  end

endmodule

// File: rtl/dbg_word_reader.sv
module dbg_word_reader
  import dbgrd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned PAGE_OFS_W = 12,
  parameter int unsigned WORD_W     = 64,
  parameter int unsigned TCS_LIMIT  = 4096,
  parameter int unsigned STATUS_W   = 32,
  parameter int unsigned NODBG_CODE = 19
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic                           req_wide,
  input  logic                           req_in_region,
  input  logic                           req_meta_busy,
  output logic                           meta_rd_en,
  output logic [ADDR_W-PAGE_OFS_W-1:0]   meta_page,
  input  logic                           meta_valid,
  input  logic [2:0]                     meta_type,
  input  logic                           meta_pending,
  input  logic                           meta_modified,
  input  logic                           meta_owner_dbg,
  input  logic [2:0]                     meta_perm,
  output logic                           mem_rd_en,
  output logic [ADDR_W-$clog2(WORD_W/8)-1:0] mem_rd_addr,
  input  logic [WORD_W-1:0]              mem_rd_data,
  output logic                           done,
  output logic [1:0]                     fault,
  output logic [WORD_W-1:0]              rd_data,
  output logic [STATUS_W-1:0]            status,
  output logic                           zf,
  output logic [4:0]                     oth_flags
);

  localparam int unsigned WOFS_W = $clog2(WORD_W / 8);
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam logic [STATUS_W-1:0] NODBG_ST = STATUS_W'(NODBG_CODE);

  logic rst_n_s;

  dbgrd_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // Captured request and transaction state
  state_e            state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              wide_q, inreg_q, busy_q, vslot_q;
  logic              cap_en, vslot_en;

  // Result registers
  logic              done_q, done_d;
  fault_e            fault_q, res_fault;
  logic [WORD_W-1:0] data_q, res_data;
  logic [STATUS_W-1:0] status_q, res_status;
  logic              zf_q, res_zf, res_en;

  // Sub-block results
  fault_e            pre_fault, pg_fault;
  logic              pg_nodbg, pg_vslot;
  logic [WORD_W-1:0] fmt_data;
  page_meta_t        meta_in;
  logic              unused_perm;

  assign unused_perm = ^meta_perm;

  assign meta_in = '{valid:     meta_valid,
                     ptype:     meta_type,
                     pending:   meta_pending,
                     modified:  meta_modified,
                     owner_dbg: meta_owner_dbg};

  dbgrd_precheck #(.WOFS_W(WOFS_W)) u_precheck (
    .addr_lo   (addr_q[WOFS_W-1:0]),
    .wide      (wide_q),
    .in_region (inreg_q),
    .meta_busy (busy_q),
    .fault     (pre_fault)
  );

  dbgrd_page_check #(.OFS_W(PAGE_OFS_W), .TCS_LIMIT(TCS_LIMIT)) u_page_check (
    .meta     (meta_in),
    .ofs      (addr_q[PAGE_OFS_W-1:0]),
    .fault    (pg_fault),
    .nodbg    (pg_nodbg),
    .is_vslot (pg_vslot)
  );

  dbgrd_word_format #(.WORD_W(WORD_W)) u_format (
    .wide   (wide_q),
    .hi_sel (addr_q[WOFS_W-1]),
    .vslot  (vslot_q),
    .word   (mem_rd_data),
    .data   (fmt_data)
  );

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    cap_en     = 1'b0;
    vslot_en   = 1'b0;
    res_en     = 1'b0;
    res_fault  = FLT_NONE;
    res_data   = '0;
    res_status = '0;
    res_zf     = 1'b0;
    meta_rd_en = 1'b0;
    mem_rd_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          state_d = ST_PRE;
        end
      end
      ST_PRE: begin
        if (pre_fault != FLT_NONE) begin
          res_en    = 1'b1;
          res_fault = pre_fault;
          state_d   = ST_IDLE;
        end else begin
          meta_rd_en = 1'b1;
          state_d    = ST_META;
        end
      end
      ST_META: begin
        if (pg_fault != FLT_NONE) begin
          res_en    = 1'b1;
          res_fault = pg_fault;
          state_d   = ST_IDLE;
        end else if (pg_nodbg) begin
          res_en     = 1'b1;
          res_status = NODBG_ST;
          res_zf     = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          mem_rd_en = 1'b1;
          vslot_en  = 1'b1;
          state_d   = ST_DATA;
        end
      end
      ST_DATA: begin
        res_en   = 1'b1;
        res_data = fmt_data;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    done_d = res_en;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q  <= '0;
      wide_q  <= 1'b0;
      inreg_q <= 1'b0;
      busy_q  <= 1'b0;
    end else if (cap_en) begin
      addr_q  <= req_addr;
      wide_q  <= req_wide;
      inreg_q <= req_in_region;
      busy_q  <= req_meta_busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vslot_q <= 1'b0;
    end else if (vslot_en) begin
      vslot_q <= pg_vslot;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      fault_q  <= FLT_NONE;
      data_q   <= '0;
      status_q <= '0;
      zf_q     <= 1'b0;
    end else if (res_en) begin
      fault_q  <= res_fault;
      data_q   <= res_data;
      status_q <= res_status;
      zf_q     <= res_zf;
    end
  end

  assign meta_page   = addr_q[ADDR_W-1:PAGE_OFS_W];
  assign mem_rd_addr = addr_q[ADDR_W-1:WOFS_W];
  assign done        = done_q;
  assign fault       = fault_q;
  assign rd_data     = data_q;
  assign status      = status_q;
  assign zf          = zf_q;
  assign oth_flags   = '0;

  // Assertions
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_q |=> !done_q);

  p_ignore_busy_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q != ST_IDLE && req_valid) |=> $stable(addr_q));

  p_align_first_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_IDLE && req_valid &&
     (req_wide ? (req_addr[2:0] != 3'd0) : (req_addr[1:0] != 2'd0)))
    |=> (!meta_rd_en && !mem_rd_en) ##1 (done_q && fault_q == FLT_PROT));

  p_nodbg_nomem_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_q && zf_q) |-> !$past(mem_rd_en));

  p_zf_status_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_q && fault_q == FLT_NONE) |-> (zf_q == (status_q == NODBG_ST)));

  p_narrow_hi_zero_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_q && fault_q == FLT_NONE && !wide_q) |-> (data_q[WORD_W-1:HALF_W] == '0));

  p_meta_single_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    meta_rd_en |=> !meta_rd_en);

endmodule

// File: tb/dbg_word_reader_bench.sv
`timescale 1ns/1ps
module dbg_word_reader_bench;

  localparam int unsigned ADDR_W = 40;
  localparam logic [63:0] W  = 64'h1122_3344_5566_7788;
  localparam logic [63:0] F1 = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic [39:0] addr;
    logic        wide;
    logic        inreg;
    logic        busy;
    logic        mv;
    logic [2:0]  mtype;
    logic        pend;
    logic        modf;
    logic        dbg;
    logic [2:0]  perm;
    logic [63:0] mem;
    logic [1:0]  efault;
    logic [63:0] edata;
    logic        ezf;
    logic        emem;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{40'h1008, 1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 3'd7, W, 2'd0, W, 1'b0, 1'b1, 8'd7},                // R7 wide regular
    '{40'h1004, 1'b0, 1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 3'd7, W, 2'd0, 64'h1122_3344, 1'b0, 1'b1, 8'd8},    // R8 upper half
    '{40'h1000, 1'b0, 1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 3'd7, W, 2'd0, 64'h5566_7788, 1'b0, 1'b1, 8'd8},    // R8 lower half
    '{40'h1004, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 3'd7, W, 2'd1, 64'd0, 1'b0, 1'b0, 8'd2},            // R2 wide misaligned beats all
    '{40'h1002, 1'b0, 1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 3'd7, W, 2'd1, 64'd0, 1'b0, 1'b0, 8'd2},            // R2 narrow misaligned
    '{40'h1008, 1'b1, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 3'd7, W, 2'd2, 64'd0, 1'b0, 1'b0, 8'd3},            // R3 region before busy
    '{40'h1008, 1'b1, 1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 3'd7, W, 2'd1, 64'd0, 1'b0, 1'b0, 8'd3},            // R3 busy before valid
    '{40'h1008, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd7, W, 2'd2, 64'd0, 1'b0, 1'b0, 8'd3},            // R3 invalid page
    '{40'h1008, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 3'd7, W, 2'd2, 64'd0, 1'b0, 1'b0, 8'd3},            // R3 type before pending
    '{40'h1008, 1'b1, 1'b1, 1'b0, 1'b1, 3'd5, 1'b0, 1'b0, 1'b1, 3'd7, W, 2'd2, 64'd0, 1'b0, 1'b0, 8'd3},            // R3 unknown type
    '{40'h1008, 1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 3'd7, W, 2'd0, 64'd0, 1'b1, 1'b0, 8'd4},            // R4 pending before debug
    '{40'h1FF8, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 1'b1, 1'b1, 3'd7, W, 2'd0, 64'd0, 1'b1, 1'b0, 8'd4},            // R4 modified before limit
    '{40'h2400, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 3'd7, W, 2'd1, 64'd0, 1'b0, 1'b0, 8'd5},            // R5 offset at limit
    '{40'h23F8, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 3'd7, W, 2'd0, W, 1'b0, 1'b1, 8'd5},                // R5 offset below limit
    '{40'h1008, 1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 3'd7, W, 2'd1, 64'd0, 1'b0, 1'b0, 8'd6},            // R6 regular no debug
    '{40'h1010, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 3'd7, W, 2'd1, 64'd0, 1'b0, 1'b0, 8'd6},            // R6 thread no debug
    '{40'h3008, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 3'd7, 64'h7, 2'd0, 64'd0, 1'b0, 1'b1, 8'd9},        // R9 low bits only
    '{40'h3004, 1'b0, 1'b1, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 3'd7, 64'h8, 2'd0, 64'hFFFF_FFFF, 1'b0, 1'b1, 8'd9}, // R9 narrow ones
    '{40'h3000, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 3'd7, 64'h8000_0000_0000_0000, 2'd0, F1, 1'b0, 1'b1, 8'd9}, // R9 debug ignored
    '{40'h3000, 1'b0, 1'b1, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 3'd7, 64'h7, 2'd0, 64'd0, 1'b0, 1'b1, 8'd9},        // R9 narrow zero
    '{40'h1008, 1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 3'd0, W, 2'd0, W, 1'b0, 1'b1, 8'd10},               // R10 no permissions
    '{40'h1008, 1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 3'd5, W, 2'd0, W, 1'b0, 1'b1, 8'd10}                // R10 mixed permissions
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_wide, req_in_region, req_meta_busy;
  logic [39:0] req_addr;
  logic        meta_rd_en;
  logic [27:0] meta_page;
  logic        meta_valid, meta_pending, meta_modified, meta_owner_dbg;
  logic [2:0]  meta_type, meta_perm;
  logic        mem_rd_en;
  logic [36:0] mem_rd_addr;
  logic [63:0] mem_rd_data;
  logic        done;
  logic [1:0]  fault;
  logic [63:0] rd_data;
  logic [31:0] status;
  logic        zf;
  logic [4:0]  oth_flags;

  int n_chk  = 0;
  int n_fail = 0;
  int n_meta, n_mem, n_done, n_badaddr;
  logic [63:0] cur_mem;
  logic [39:0] exp_addr;

  always #2.5 clk = ~clk;

  dbg_word_reader #(.TCS_LIMIT(1024)) u_dbg_word_reader (
    .clk, .rst_n, .req_valid, .req_addr, .req_wide, .req_in_region, .req_meta_busy,
    .meta_rd_en, .meta_page, .meta_valid, .meta_type, .meta_pending, .meta_modified,
    .meta_owner_dbg, .meta_perm, .mem_rd_en, .mem_rd_addr, .mem_rd_data,
    .done, .fault, .rd_data, .status, .zf, .oth_flags
  );

  // Memory model and port monitor
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= cur_mem;
      n_mem = n_mem + 1;
      if (mem_rd_addr != exp_addr[39:3]) n_badaddr = n_badaddr + 1;
    end
    if (meta_rd_en) begin
      n_meta = n_meta + 1;
      if (meta_page != exp_addr[39:12]) n_badaddr = n_badaddr + 1;
    end
    if (done) n_done = n_done + 1;
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    req_addr       = v.addr;
    req_wide       = v.wide;
    req_in_region  = v.inreg;
    req_meta_busy  = v.busy;
    meta_valid     = v.mv;
    meta_type      = v.mtype;
    meta_pending   = v.pend;
    meta_modified  = v.modf;
    meta_owner_dbg = v.dbg;
    meta_perm      = v.perm;
    cur_mem        = v.mem;
    exp_addr       = v.addr;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic run_vec(input vec_t v);
    bit seen;
    string rq;
    rq = $sformatf("R%0d", v.req);
    @(negedge clk);
    load(v);
    n_meta = 0; n_mem = 0; n_done = 0; n_badaddr = 0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(seen);
    chk(seen, {rq, " done"}, 64'(seen), 64'd1);
    chk(fault == v.efault, {rq, " fault"}, 64'(fault), 64'(v.efault));
    chk(n_mem == int'(v.emem), {rq, " memory reads"}, 64'(n_mem), 64'(v.emem));
    chk(n_badaddr == 0, {rq, " R12 lookup address"}, 64'(n_badaddr), 64'd0);
    if (v.req == 8'd2) chk(n_meta == 0, "R2 no lookup", 64'(n_meta), 64'd0);
    if (v.efault == 2'd0) begin
      chk(rd_data == v.edata, {rq, " data"}, rd_data, v.edata);
      chk(zf == v.ezf, {rq, " zf"}, 64'(zf), 64'(v.ezf));
      chk(status == (v.ezf ? 32'd19 : 32'd0), {rq, " status"}, 64'(status), v.ezf ? 64'd19 : 64'd0);
      chk(oth_flags == 5'd0, "R11 other flags", 64'(oth_flags), 64'd0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    load(VECS[0]);
    n_meta = 0; n_mem = 0; n_done = 0; n_badaddr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state: R1, R12
    chk(done == 1'b0, "R1 reset done", 64'(done), 64'd0);
    chk(fault == 2'd0, "R1 reset fault", 64'(fault), 64'd0);
    chk(meta_rd_en == 1'b0 && mem_rd_en == 1'b0, "R12 reset strobes",
        64'({meta_rd_en, mem_rd_en}), 64'd0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R1: a second request during a transaction is ignored
    begin
      bit seen;
      @(negedge clk);
      load(VECS[0]);
      n_meta = 0; n_mem = 0; n_done = 0; n_badaddr = 0;
      req_valid = 1'b1;
      @(negedge clk);
      req_addr = 40'h5010;
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = 40'h1008;
      wait_done(seen);
      chk(seen && rd_data == W, "R1 first request result", rd_data, W);
      repeat (10) @(negedge clk);
      chk(n_done == 1, "R1 single done", 64'(n_done), 64'd1);
      chk(n_mem == 1 && n_badaddr == 0, "R1 no second read", 64'(n_mem), 64'd1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule